// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block is the control part of an I2C master that ends a transfer with a STOP condition when software asks for one. It holds the bus after a START, clocks out nine-bit bytes (eight data clocks and one acknowledge clock), and parks SCL low in a wait state after a byte. The wait falls either after the eighth clock or after the ninth clock, as a select input chooses. A stop request is stored in a pending flag that software can read back. The sequencer carries the request out at the next wait: it pulls SDA low while SCL is low, lets SCL go high, and counts a setup delay. Then it releases SDA, so that SDA rises while SCL is high.

Both bus lines are open-drain. The block only produces drive-low enables, and it samples SCL so that a slave holding the clock low stretches the setup count. The data shift register, address matching and slave operation are outside this block. The bit value to place on SDA comes from the data path on `sda_bit_i`. All pins are plain control and status levels or one-cycle strobes. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `i2c_stop_seq`

## Requirements
- R1: After reset both drive enables are 0 (lines released), and `stp_o` and `tx_o` read 0.
- R2: A `sta_req_i` strobe while idle, enabled and in master mode pulls SDA low with SCL released (START). After `HALF_CYC` cycles SCL is held low in the wait state.
- R3: A `stp_wr_i` strobe in the same cycle as `sta_req_i` is ignored: the flag stays clear and no STOP follows.
- R4: A `stp_wr_i` strobe while `master_i` is 0 is ignored.
- R5: An accepted stop write sets the pending flag. `stp_o` reads 0 in the cycle right after the write and 1 from the next cycle on, while the flag is pending.
- R6: A stop write while the flag is pending is ignored and does not re-mask `stp_o`, which stays 1.
- R7: The STOP runs as follows. SDA is driven low with SCL low for `HALF_CYC` cycles. Then SCL is released. After SCL has been sampled high for `SETUP_CYC` cycles, SDA is released, so it rises while SCL is high. Then the block is idle.
- R8: The setup count advances only while SCL is sampled high. A slave stretching SCL low delays the STOP, and SDA stays low meanwhile.
- R9: With `wait9_i`=0, the master waits after the 8th clock of a byte. A stop there is produced in the high phase of that byte's 9th clock (9 SCL rises after START for one byte). With `wait9_i`=1, the STOP clock follows the 9th clock (two bytes give 19 rises).
- R10: `arb_lost_i`, `stop_det_i` and `rel_i` each clear the pending flag at the next edge. `arb_lost_i` and `rel_i` also release both lines and return the block to idle.
- R11: While `en_i` is 0, `stp_o` reads 0 at once. At the next edge the flag clears and both lines are released, and the flag stays clear after re-enable.
- R12: `tx_load_i` in the after-9th wait starts a byte in transmit mode (`tx_o`=1). In transmit mode clocks 1-8 drive SDA low when `sda_bit_i`=0 and clock 9 is released; in receive mode clocks 1-8 are released and clock 9 drives `sda_bit_i`. A `wrel_i` in the after-9th wait clears `tx_o`, so SDA stays released in the data clocks of the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable; 0 aborts and invalidates the flag |
| master_i | input | 1 | Master mode status |
| wait9_i | input | 1 | Wait position: 0 after 8th clock, 1 after 9th clock |
| sta_req_i | input | 1 | Start request strobe |
| stp_wr_i | input | 1 | Stop request write strobe |
| wrel_i | input | 1 | Wait release strobe |
| tx_load_i | input | 1 | Transmit byte load strobe (also releases wait) |
| sda_bit_i | input | 1 | Bit the data path wants on SDA (1 = release) |
| arb_lost_i | input | 1 | Arbitration lost flag |
| stop_det_i | input | 1 | STOP detected on the bus |
| rel_i | input | 1 | Communication release strobe |
| scl_i | input | 1 | Sampled SCL line level |
| scl_oe_o | output | 1 | Drive SCL low when 1 |
| sda_oe_o | output | 1 | Drive SDA low when 1 |
| stp_o | output | 1 | Readable stop-request flag |
| tx_o | output | 1 | Transmit mode status |

## Verification
Flag results are due one edge after the strobe. `stp_o` is 0 in the sample after the capture edge and 1 in the sample after the following edge, and a clear strobe drops it in the sample after its edge. The bench drives inputs just after a rising edge and samples on falling edges, so each flag check lands in exactly that sample. Bus results take whole phases: a STOP needs `HALF_CYC` low cycles plus `SETUP_CYC` high samples, and a byte needs nine clocks of 2×`HALF_CYC` cycles. The bench therefore waits with margin and lets a falling-edge bus monitor pop the expected STOP from a queue, comparing the SCL rise count and the high-level run before the SDA rise.

// File: rtl/stp_seq_pkg.sv
package stp_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, // bus free, both lines released
    ST_STA,  // START: SDA low, SCL released
    ST_WAIT, // SCL held low after a byte or a START
    ST_BLO,  // byte clock, low phase
    ST_BHI,  // byte clock, high phase
    ST_PLO,  // STOP: SDA low, SCL low
    ST_PHI   // STOP: SDA low, SCL released, setup count
  } seq_st_t;
endpackage

// File: rtl/stp_req_flag.sv
module stp_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic master_i,
  input  logic sta_req_i,
  input  logic stp_wr_i,
  input  logic arb_lost_i,
  input  logic stop_det_i,
  input  logic rel_i,
  output logic pend_o,
  output logic stp_o
);
  logic accept, clr, fresh;

  assign accept = stp_wr_i & master_i & en_i & ~sta_req_i & ~pend_o;
  assign clr    = arb_lost_i | stop_det_i | rel_i | ~en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      fresh  <= 1'b0;
    end else begin
      if (clr)         pend_o <= 1'b0;
      else if (accept) pend_o <= 1'b1;
      fresh <= accept & ~clr;
    end
  end

  // invalid while disabled, and masked in the cycle after the write
  assign stp_o = pend_o & en_i & ~fresh;
endmodule

// File: rtl/stp_phase_tmr.sv
module stp_phase_tmr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (load_i)                 cnt <= load_val_i;
    else if (dec_i && cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign last_o = (cnt == CNT_W'(1));
endmodule

// File: rtl/stp_bus_fsm.sv
module stp_bus_fsm
  import stp_seq_pkg::*;
#(
  parameter int HALF_CYC  = 4,
  parameter int SETUP_CYC = 4,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             master_i,
  input  logic             wait9_i,
  input  logic             sta_req_i,
  input  logic             wrel_i,
  input  logic             tx_load_i,
  input  logic             sda_bit_i,
  input  logic             arb_lost_i,
  input  logic             rel_i,
  input  logic             scl_i,
  input  logic             pend_i,
  input  logic             tmr_last_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             tmr_dec_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             tx_o,
  output seq_st_t          st_o
);
  localparam logic [3:0] LAST_DATA = 4'd8;
  localparam logic [3:0] ACK_CLK   = 4'd9;

  seq_st_t    st, st_n;
  logic [3:0] bitn, bitn_n;
  logic       pos9, pos9_n, tx, tx_n;
  logic       abort, done;

  assign abort = arb_lost_i | rel_i | ~en_i;

  // high phases advance only while SCL is really high (stretching)
  always_comb begin
    case (st)
      ST_STA, ST_BLO, ST_PLO: tmr_dec_o = 1'b1;
      ST_BHI, ST_PHI:         tmr_dec_o = scl_i;
      default:                tmr_dec_o = 1'b0;
    endcase
  end
  assign done = tmr_last_i & tmr_dec_o;

  always_comb begin
    st_n   = st;
    bitn_n = bitn;
    pos9_n = pos9;
    tx_n   = tx;
    if (abort) begin
      st_n = ST_IDLE;
      tx_n = 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (sta_req_i && master_i) st_n = ST_STA;
        ST_STA: if (done) begin
          st_n   = ST_WAIT;
          pos9_n = 1'b1;
          tx_n   = 1'b0;
        end
        ST_WAIT: begin
          if (pend_i) st_n = ST_PLO;
          else if (tx_load_i || wrel_i) begin
            st_n = ST_BLO;
            if (pos9) begin
              bitn_n = 4'd1;
              tx_n   = tx_load_i;  // wait release after 9th ends transmit
            end else begin
              bitn_n = ACK_CLK;
            end
          end
        end
        ST_BLO: if (done) st_n = ST_BHI;
        ST_BHI: if (done) begin
          if (bitn == LAST_DATA && !wait9_i) begin
            st_n   = ST_WAIT;
            pos9_n = 1'b0;
          end else if (bitn == ACK_CLK) begin
            st_n   = ST_WAIT;
            pos9_n = 1'b1;
          end else begin
            st_n   = ST_BLO;
            bitn_n = bitn + 4'd1;
          end
        end
        ST_PLO: if (done) st_n = ST_PHI;
        ST_PHI: if (done) begin
          st_n = ST_IDLE;
          tx_n = 1'b0;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      bitn <= '0;
      pos9 <= 1'b1;
      tx   <= 1'b0;
    end else begin
      st   <= st_n;
      bitn <= bitn_n;
      pos9 <= pos9_n;
      tx   <= tx_n;
    end
  end

  assign tmr_load_o = (st_n != st);
  assign tmr_val_o  = (st_n == ST_PHI) ? CNT_W'(SETUP_CYC) : CNT_W'(HALF_CYC);

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    case (st)
      ST_STA: sda_oe_o = 1'b1;
      ST_WAIT: scl_oe_o = 1'b1;
      ST_BLO, ST_BHI: begin
        scl_oe_o = (st == ST_BLO);
        if (bitn == ACK_CLK) sda_oe_o = ~tx & ~sda_bit_i;
        else                 sda_oe_o = tx & ~sda_bit_i;
      end
      ST_PLO: begin
        scl_oe_o = 1'b1;
        sda_oe_o = 1'b1;
      end
      ST_PHI: sda_oe_o = 1'b1;
      default: ;
    endcase
  end

  assign tx_o = tx;
  assign st_o = st;
endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq
  import stp_seq_pkg::*;
#(
  parameter int HALF_CYC  = 4,
  parameter int SETUP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic master_i,
  input  logic wait9_i,
  input  logic sta_req_i,
  input  logic stp_wr_i,
  input  logic wrel_i,
  input  logic tx_load_i,
  input  logic sda_bit_i,
  input  logic arb_lost_i,
  input  logic stop_det_i,
  input  logic rel_i,
  input  logic scl_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic stp_o,
  output logic tx_o
);
  localparam int MAX_CYC = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             stp_pend;
  logic             tmr_load, tmr_dec, tmr_last;
  logic [CNT_W-1:0] tmr_val;
  seq_st_t          st_q;

  stp_req_flag u_flag (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .master_i(master_i),
    .sta_req_i(sta_req_i), .stp_wr_i(stp_wr_i), .arb_lost_i(arb_lost_i),
    .stop_det_i(stop_det_i), .rel_i(rel_i), .pend_o(stp_pend), .stp_o(stp_o)
  );

  stp_phase_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .dec_i(tmr_dec), .last_o(tmr_last)
  );

  stp_bus_fsm #(.HALF_CYC(HALF_CYC), .SETUP_CYC(SETUP_CYC), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .master_i(master_i),
    .wait9_i(wait9_i), .sta_req_i(sta_req_i), .wrel_i(wrel_i),
    .tx_load_i(tx_load_i), .sda_bit_i(sda_bit_i), .arb_lost_i(arb_lost_i),
    .rel_i(rel_i), .scl_i(scl_i), .pend_i(stp_pend), .tmr_last_i(tmr_last),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .tmr_dec_o(tmr_dec),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .tx_o(tx_o), .st_o(st_q)
  );
endmodule

// File: rtl/stp_seq_chk.sv
module stp_seq_chk
  import stp_seq_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    en_i,
  input logic    master_i,
  input logic    sta_req_i,
  input logic    stp_wr_i,
  input logic    arb_lost_i,
  input logic    stop_det_i,
  input logic    rel_i,
  input logic    scl_i,
  input logic    scl_oe_o,
  input logic    sda_oe_o,
  input logic    stp_o,
  input logic    pend,
  input seq_st_t st
);
  // R5
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> !stp_o);

  // R6
  rpt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && stp_wr_i && en_i && !arb_lost_i && !stop_det_i && !rel_i)
    |=> (stp_o || !en_i));

  // R3
  same_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && stp_wr_i && sta_req_i) |=> !pend);

  // R4
  slave_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && stp_wr_i && !master_i) |=> !pend);

  // R10
  clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost_i || stop_det_i || rel_i) |=> !pend);

  // R11
  off_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!pend && !scl_oe_o && !sda_oe_o));

  // R7
  stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe_o) && $past(st == ST_PHI)) |-> scl_i);
endmodule

bind i2c_stop_seq stp_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .master_i(master_i),
  .sta_req_i(sta_req_i), .stp_wr_i(stp_wr_i), .arb_lost_i(arb_lost_i),
  .stop_det_i(stop_det_i), .rel_i(rel_i), .scl_i(scl_i),
  .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .stp_o(stp_o),
  .pend(stp_pend), .st(st_q)
);

// File: tb/sim_i2c_stop_seq.sv
module sim_i2c_stop_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF      = 4;
  localparam int SETUP     = 4;

  localparam int S_STA = 0, S_STP = 1, S_WREL = 2, S_TX = 3, S_ARB = 4, S_REL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b1, master_i = 1'b1, wait9_i = 1'b1;
  logic sta_req_i = 1'b0, stp_wr_i = 1'b0, wrel_i = 1'b0, tx_load_i = 1'b0;
  logic sda_bit_i = 1'b1, arb_lost_i = 1'b0, stop_det_i = 1'b0, rel_i = 1'b0;
  logic stretch = 1'b0;
  logic scl_oe_o, sda_oe_o, stp_o, tx_o;
  logic scl_bus, sda_bus;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int rises = 0;
  int hi_run = 0;
  bit seen_start = 1'b0;
  bit p_scl = 1'b1, p_sda = 1'b1;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // open-drain bus with pull-ups; a slave may stretch SCL
  assign scl_bus = ~(scl_oe_o | stretch);
  assign sda_bus = ~sda_oe_o;

  i2c_stop_seq #(.HALF_CYC(HALF), .SETUP_CYC(SETUP)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .master_i(master_i),
    .wait9_i(wait9_i), .sta_req_i(sta_req_i), .stp_wr_i(stp_wr_i),
    .wrel_i(wrel_i), .tx_load_i(tx_load_i), .sda_bit_i(sda_bit_i),
    .arb_lost_i(arb_lost_i), .stop_det_i(stop_det_i), .rel_i(rel_i),
    .scl_i(scl_bus), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
    .stp_o(stp_o), .tx_o(tx_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int which);
    @(posedge clk); #1;
    case (which)
      S_STA:  sta_req_i  = 1'b1;
      S_STP:  stp_wr_i   = 1'b1;
      S_WREL: wrel_i     = 1'b1;
      S_TX:   tx_load_i  = 1'b1;
      S_ARB:  arb_lost_i = 1'b1;
      default: rel_i     = 1'b1;
    endcase
    @(posedge clk); #1;
    sta_req_i = 1'b0; stp_wr_i = 1'b0; wrel_i = 1'b0;
    tx_load_i = 1'b0; arb_lost_i = 1'b0; rel_i = 1'b0;
  endtask

  // monitor: bus events, scoreboard for expected STOPs, stop detect feedback
  always @(negedge clk) begin
    stop_det_i <= 1'b0;
    if (rst_n) begin
      if (p_scl && scl_bus && p_sda && !sda_bus) begin
        rises = 0;
        seen_start = 1'b1;
      end else if (p_scl && scl_bus && !p_sda && sda_bus) begin
        stop_det_i <= 1'b1;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected STOP", 1, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(rises == e, "R9 SCL rises before STOP", rises, e);
          chk(hi_run >= SETUP, "R7 SCL high run before SDA rise", hi_run, SETUP);
        end
      end
      if (!p_scl && scl_bus) rises++;
      hi_run = scl_bus ? hi_run + 1 : 0;
    end
    p_scl = scl_bus;
    p_sda = sda_bus;
  end

  task automatic abort_case(input int kind, input string tag);
    sda_bit_i = 1'b1;
    strobe(S_STA); idle(20);
    strobe(S_WREL); idle(10);
    strobe(S_STP); idle(3);
    chk(stp_o == 1'b1, "R5 pending before clear", int'(stp_o), 1);
    strobe(kind);
    @(negedge clk);
    chk(stp_o == 1'b0, tag, int'(stp_o), 0);
    chk(!scl_oe_o && !sda_oe_o, tag, int'({scl_oe_o, sda_oe_o}), 0);
    idle(5);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!scl_oe_o && !sda_oe_o, "R1 lines released", int'({scl_oe_o, sda_oe_o}), 0);
    chk(!stp_o && !tx_o, "R1 flags clear", int'({stp_o, tx_o}), 0);

    // R4: not master
    master_i = 1'b0;
    strobe(S_STP); idle(2);
    chk(stp_o == 1'b0, "R4 slave write ignored", int'(stp_o), 0);
    master_i = 1'b1;

    // R2: START then wait
    strobe(S_STA); idle(20);
    chk(seen_start, "R2 START seen", int'(seen_start), 1);
    chk(scl_oe_o == 1'b1, "R2 SCL held low", int'(scl_oe_o), 1);

    // R3: start and stop together
    @(posedge clk); #1 sta_req_i = 1'b1; stp_wr_i = 1'b1;
    @(posedge clk); #1 sta_req_i = 1'b0; stp_wr_i = 1'b0;
    @(negedge clk);
    chk(stp_o == 1'b0, "R3 same-cycle write ignored", int'(stp_o), 0);
    idle(40);
    chk(scl_oe_o == 1'b1, "R3 still waiting", int'(scl_oe_o), 1);

    // R9 wait after 8th clock, R5, R6
    wait9_i = 1'b0;
    strobe(S_WREL); idle(100);
    chk(scl_oe_o == 1'b1, "R9 waiting after 8th clock", int'(scl_oe_o), 1);
    exp_q.push_back(9);
    @(posedge clk); #1 stp_wr_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(stp_o == 1'b0, "R5 read after write", int'(stp_o), 0);
    @(posedge clk); #1 stp_wr_i = 1'b0;
    @(negedge clk);
    chk(stp_o == 1'b1, "R6 repeat write keeps flag", int'(stp_o), 1);
    idle(40);
    chk(stp_o == 1'b0, "R10 cleared by stop detect", int'(stp_o), 0);
    chk(!scl_oe_o && !sda_oe_o, "R7 idle after STOP", int'({scl_oe_o, sda_oe_o}), 0);
    chk(exp_q.size() == 0, "R9 STOP produced", exp_q.size(), 0);

    // R12 transmit, then R8 stretching with wait after 9th clock
    wait9_i = 1'b1; sda_bit_i = 1'b0;
    strobe(S_STA); idle(20);
    strobe(S_TX); idle(20);
    chk(tx_o == 1'b1, "R12 transmit mode", int'(tx_o), 1);
    chk(sda_oe_o == 1'b1, "R12 data bit driven", int'(sda_oe_o), 1);
    idle(100);
    strobe(S_WREL);
    @(negedge clk);
    chk(tx_o == 1'b0, "R12 release clears transmit", int'(tx_o), 0);
    idle(20);
    chk(sda_oe_o == 1'b0, "R12 SDA released in receive", int'(sda_oe_o), 0);
    idle(100);
    @(posedge clk); #1 stretch = 1'b1;
    exp_q.push_back(19);
    strobe(S_STP); idle(30);
    chk(sda_oe_o == 1'b1, "R8 SDA held low while stretched", int'(sda_oe_o), 1);
    chk(exp_q.size() == 1, "R8 no STOP while stretched", exp_q.size(), 1);
    @(posedge clk); #1 stretch = 1'b0;
    idle(30);
    chk(exp_q.size() == 0, "R8 STOP after stretch", exp_q.size(), 0);
    chk(stp_o == 1'b0, "R10 flag clear after STOP", int'(stp_o), 0);

    // R10 clear sources that abort
    abort_case(S_ARB, "R10 arbitration lost");
    abort_case(S_REL, "R10 communication release");

    // R11 disable
    strobe(S_STA); idle(20);
    strobe(S_WREL); idle(10);
    strobe(S_STP); idle(3);
    @(posedge clk); #1 en_i = 1'b0;
    #1 chk(stp_o == 1'b0, "R11 invalid while disabled", int'(stp_o), 0);
    @(negedge clk);
    chk(!scl_oe_o && !sda_oe_o, "R11 lines released", int'({scl_oe_o, sda_oe_o}), 0);
    @(posedge clk); #1 en_i = 1'b1;
    idle(3);
    chk(stp_o == 1'b0, "R11 flag cleared", int'(stp_o), 0);

    chk(exp_q.size() == 0, "R7 scoreboard empty", exp_q.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule